// File: doc/BRIEF.md
# Loop-bound predicate mask generator

This unit builds the governing predicate for one strip of a vectorised loop. It takes two scalar operands: a start index and a loop bound. It also takes a comparison kind, an element size and an operand-width bit. From these it produces a per-byte predicate mask over a vector of parameterised length, together with four condition flags. Element i of the vector is active while the start index plus i still compares true against the bound. From the first element that fails onward, every element is inactive.

The control inputs are the raw fields of the instruction word, so a decoder can wire them straight through. A valid strobe captures one request, and the mask and flags appear in registers on the next clock. While no request is presented, the outputs keep their last value.

Top module: `loop_mask_gen`

## Requirements
- R1: `valid_out` is high exactly in the cycle after a cycle with `valid_in` high. After reset, `valid_out`, `pred` and `nzcv` are all zero.
- R2: The `cmp` codes are 010 signed less-than, 011 signed less-or-equal, 110 unsigned lower-than and 111 unsigned lower-or-same. Element i is true when (`op_a` + i) compares true against `op_b`.
- R3: While `valid_in` is low, `pred` and `nzcv` keep their previous values.
- R4: `size` 00, 01, 10 and 11 select elements of E = 1, 2, 4 and 8 bytes. There are VL/8/E elements. Element i drives `pred` bit i*E, and every other bit is zero.
- R5: The true elements form an unbroken run starting at element 0. Once one element fails, no higher element is true.
- R6: `nzcv` is {N,Z,C,V} on bits 3..0. N means element 0 is true, Z means no element is true, C means the last element is not true, and V is always 0.
- R7: With `is64`=0, only bits 31:0 of each operand are used. They are sign-extended for signed kinds and zero-extended for unsigned kinds, and bits 63:32 have no effect.
- R8: An incremented index that would exceed the largest value of the operand width does not wrap, and that element fails.
- R9: A `cmp` code with bit 1 clear gives an all-zero mask, with `nzcv` = 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Request strobe |
| op_a | input | 64 | Start index |
| op_b | input | 64 | Loop bound |
| is64 | input | 1 | 1: 64-bit operands, 0: 32-bit |
| size | input | 2 | Element size code |
| cmp | input | 3 | Comparison kind code |
| valid_out | output | 1 | Result valid |
| pred | output | VL/8 | Predicate mask, one bit per byte |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The hardest situation to reach is an incremented index that crosses the top of the operand range partway along the vector. If the adder wrapped, the element after the crossing would compare true again. The stimulus places the start index one or two below the maximum for 32-bit unsigned and 64-bit signed operands, with the bound at the maximum. In the 32-bit cases it also fills the upper operand halves with unrelated data, so the extension logic and the no-wrap rule are exercised together.

// File: rtl/lmg_pkg.sv
package lmg_pkg;
  // extra precision: one bit for sign of unsigned values, one for the increment
  localparam int unsigned EXT_BITS = 2;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_WORD = 2'b10,
    ESZ_DBL  = 2'b11
  } elem_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/lmg_rst_sync.sv
module lmg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lmg_operand_prep.sv
module lmg_operand_prep #(
  parameter int unsigned OPW = 64,
  parameter int unsigned XW  = OPW + lmg_pkg::EXT_BITS
) (
  input  logic [OPW-1:0]        a_raw,
  input  logic [OPW-1:0]        b_raw,
  input  logic                  wide,
  input  logic                  uns,
  output logic signed [XW-1:0]  a_ext,
  output logic signed [XW-1:0]  b_ext
);
  localparam int unsigned HW = OPW / 2;

  logic [HW-1:0] a_lo, b_lo;
  assign a_lo = a_raw[HW-1:0];
  assign b_lo = b_raw[HW-1:0];

  always_comb begin
    if (wide) begin
      if (uns) begin
        a_ext = {{(XW-OPW){1'b0}}, a_raw};
        b_ext = {{(XW-OPW){1'b0}}, b_raw};
      end else begin
        a_ext = {{(XW-OPW){a_raw[OPW-1]}}, a_raw};
        b_ext = {{(XW-OPW){b_raw[OPW-1]}}, b_raw};
      end
    end else begin
      if (uns) begin
        a_ext = {{(XW-HW){1'b0}}, a_lo};
        b_ext = {{(XW-HW){1'b0}}, b_lo};
      end else begin
        a_ext = {{(XW-HW){a_lo[HW-1]}}, a_lo};
        b_ext = {{(XW-HW){b_lo[HW-1]}}, b_lo};
      end
    end
  end
endmodule

// File: rtl/lmg_elem_chain.sv
module lmg_elem_chain #(
  parameter int unsigned NMAX = 32,
  parameter int unsigned XW   = 66
) (
  input  logic signed [XW-1:0] a_ext,
  input  logic signed [XW-1:0] b_ext,
  input  logic                 incl,
  input  logic                 kind_ok,
  output logic [NMAX-1:0]      pass
);
  logic [NMAX-1:0] hit;

  for (genvar i = 0; i < NMAX; i++) begin : g_elem
    localparam logic signed [XW-1:0] OFFSET = XW'(i);
    logic signed [XW-1:0] idx;
    assign idx    = a_ext + OFFSET;
    assign hit[i] = incl ? (idx <= b_ext) : (idx < b_ext);
    if (i == 0) begin : g_head
      assign pass[i] = kind_ok & hit[i];
    end else begin : g_tail
      // once an element fails, every later element stays false
      assign pass[i] = pass[i-1] & hit[i];
    end
  end
endmodule

// File: rtl/lmg_mask_flags.sv
module lmg_mask_flags #(
  parameter int unsigned PW = 32
) (
  input  logic [PW-1:0]   pass,
  input  logic [1:0]      size,
  output logic [PW-1:0]   mask,
  output lmg_pkg::flags_t flags
);
  int sh;
  int nelem;
  logic any_true;

  always_comb begin
    sh       = int'(size);
    nelem    = int'(PW) >> sh;
    mask     = '0;
    any_true = 1'b0;
    for (int j = 0; j < int'(PW); j++) begin
      if ((j & ((1 << sh) - 1)) == 0) mask[j] = pass[j >> sh];
      if (j < nelem) any_true = any_true | pass[j];
    end
    flags.n = pass[0];
    flags.z = ~any_true;
    flags.c = ~pass[nelem-1];
    flags.v = 1'b0;
  end
endmodule

// File: rtl/loop_mask_gen.sv
module loop_mask_gen #(
  parameter int unsigned VL  = 256,
  parameter int unsigned OPW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [OPW-1:0]    op_a,
  input  logic [OPW-1:0]    op_b,
  input  logic              is64,
  input  logic [1:0]        size,
  input  logic [2:0]        cmp,
  output logic              valid_out,
  output logic [VL/8-1:0]   pred,
  output logic [3:0]        nzcv
);
  import lmg_pkg::*;

  localparam int unsigned PW = VL / 8;
  localparam int unsigned XW = OPW + EXT_BITS;

  logic rst_ns;
  logic signed [XW-1:0] a_ext, b_ext;
  logic [PW-1:0] pass, mask_c;
  flags_t flags_c;

  logic          valid_q, valid_d;
  logic [PW-1:0] pred_q, pred_d;
  logic [3:0]    nzcv_q, nzcv_d;

  lmg_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_ns)
  );

  lmg_operand_prep #(.OPW(OPW), .XW(XW)) u_prep (
    .a_raw(op_a),
    .b_raw(op_b),
    .wide (is64),
    .uns  (cmp[2]),
    .a_ext(a_ext),
    .b_ext(b_ext)
  );

  lmg_elem_chain #(.NMAX(PW), .XW(XW)) u_chain (
    .a_ext  (a_ext),
    .b_ext  (b_ext),
    .incl   (cmp[0]),
    .kind_ok(cmp[1]),
    .pass   (pass)
  );

  lmg_mask_flags #(.PW(PW)) u_mf (
    .pass (pass),
    .size (size),
    .mask (mask_c),
    .flags(flags_c)
  );

  always_comb begin
    valid_d = valid_in;
    pred_d  = pred_q;
    nzcv_d  = nzcv_q;
    if (valid_in) begin
      pred_d = mask_c;
      nzcv_d = flags_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      valid_q <= 1'b0;
      pred_q  <= '0;
      nzcv_q  <= '0;
    end else begin
      valid_q <= valid_d;
      pred_q  <= pred_d;
      nzcv_q  <= nzcv_d;
    end
  end

  assign valid_out = valid_q;
  assign pred      = pred_q;
  assign nzcv      = nzcv_q;

  // R1: one-cycle result latency
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_ns)
    valid_in |=> valid_out);

  // R3: outputs frozen without a request
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !valid_in |=> ($stable(pred) && $stable(nzcv)));

  // R6: N agrees with element 0 of the registered mask
  a_r6_n_first: assert property (@(posedge clk) disable iff (!rst_ns)
    valid_out |-> (nzcv[3] == pred[0]));

  // R6: Z agrees with an empty registered mask
  a_r6_z_empty: assert property (@(posedge clk) disable iff (!rst_ns)
    valid_out |-> (nzcv[2] == (pred == '0)));
endmodule

// File: tb/sim_loop_mask_gen.sv
module sim_loop_mask_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [63:0] op_a, op_b;
  logic        is64;
  logic [1:0]  size;
  logic [2:0]  cmp;
  logic        valid_out;
  logic [PW-1:0] pred;
  logic [3:0]  nzcv;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [PW-1:0] exp_pred;
  logic [3:0]    exp_nzcv;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_mask_gen u0 (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_a(op_a), .op_b(op_b),
    .is64(is64), .size(size), .cmp(cmp), .valid_out(valid_out),
    .pred(pred), .nzcv(nzcv)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference from the requirements
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic w,
                       input logic [1:0] sz, input logic [2:0] k);
    logic signed [67:0] ax, bx, s;
    bit alive, any, ok;
    int ne;
    if (w) begin
      ax = k[2] ? {4'b0, a} : {{4{a[63]}}, a};
      bx = k[2] ? {4'b0, b} : {{4{b[63]}}, b};
    end else begin
      ax = k[2] ? {36'b0, a[31:0]} : {{36{a[31]}}, a[31:0]};
      bx = k[2] ? {36'b0, b[31:0]} : {{36{b[31]}}, b[31:0]};
    end
    ne = PW >> sz;
    exp_pred = '0;
    alive = k[1];
    any = 0;
    exp_nzcv = 4'b0000;
    for (int e = 0; e < ne; e++) begin
      s = ax + 68'(e);
      ok = alive && (k[0] ? (s <= bx) : (s < bx));
      alive = ok;
      if (ok) begin
        exp_pred[e << sz] = 1'b1;
        any = 1;
      end
      if (e == 0) exp_nzcv[3] = ok;
      if (e == ne - 1) exp_nzcv[1] = !ok;
    end
    exp_nzcv[2] = !any;
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic w,
                       input logic [1:0] sz, input logic [2:0] k);
    @(negedge clk);
    op_a = a; op_b = b; is64 = w; size = sz; cmp = k; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic run_vec(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic w, input logic [1:0] sz, input logic [2:0] k);
    apply(a, b, w, sz, k);
    model(a, b, w, sz, k);
    check({req, " valid"}, 64'(valid_out), 64'd1);
    check({req, " pred"}, 64'(pred), 64'(exp_pred));
    check({req, " nzcv"}, 64'(nzcv), 64'(exp_nzcv));
  endtask

  task automatic t_reset;
    check("R1 reset valid", 64'(valid_out), 64'd0);
    check("R1 reset pred", 64'(pred), 64'd0);
    check("R1 reset nzcv", 64'(nzcv), 64'd0);
  endtask

  task automatic t_kinds;
    // R2 signed strict, words: 0..3 below 4 -> bits 0,4,8,12
    run_vec("R2 lt words", 64'd0, 64'd4, 1'b1, 2'b10, 3'b010);
    check("R2 lt words literal", 64'(pred), 64'h0000_1111);
    check("R6 partial flags", 64'(nzcv), 64'b1010);
    // R2 signed inclusive with negative start
    run_vec("R2 le signed", -64'sd3, 64'd2, 1'b1, 2'b00, 3'b011);
    check("R2 le signed literal", 64'(pred), 64'h0000_003F);
    // R2 unsigned strict: huge start is not below small bound
    run_vec("R2 lo unsigned", 64'hFFFF_FFFF_FFFF_FFF0, 64'd5, 1'b1, 2'b00, 3'b110);
    check("R2 lo unsigned literal", 64'(pred), 64'd0);
    // R2 unsigned inclusive
    run_vec("R2 ls unsigned", 64'd10, 64'd12, 1'b1, 2'b01, 3'b111);
    check("R2 ls literal", 64'(pred), 64'h0000_0015);
  endtask

  task automatic t_sizes;
    // R4 all elements true at every size
    run_vec("R4 dbl all", 64'd0, 64'd100, 1'b1, 2'b11, 3'b010);
    check("R4 dbl literal", 64'(pred), 64'h0101_0101);
    check("R6 all true flags", 64'(nzcv), 64'b1000);
    run_vec("R4 half all", 64'd0, 64'd100, 1'b1, 2'b01, 3'b010);
    check("R4 half literal", 64'(pred), 64'h5555_5555);
    run_vec("R4 byte all", 64'd0, 64'd100, 1'b1, 2'b00, 3'b010);
    check("R4 byte literal", 64'(pred), 64'hFFFF_FFFF);
  endtask

  task automatic t_prefix;
    // R5 run from element 0, stops at bound
    run_vec("R5 prefix", 64'd7, 64'd20, 1'b1, 2'b00, 3'b011);
    check("R5 prefix literal", 64'(pred), 64'h0000_3FFF);
    // R6 empty mask
    run_vec("R6 empty", 64'd5, 64'd5, 1'b1, 2'b00, 3'b010);
    check("R6 empty literal", 64'(nzcv), 64'b0110);
  endtask

  task automatic t_narrow;
    // R7 sign extension of low half, upper half junk
    run_vec("R7 signed narrow", 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 1'b0, 2'b00, 3'b010);
    check("R7 signed literal", 64'(pred), 64'h3);
    // R7 same bits as unsigned: 0xFFFFFFFF is not below 1
    run_vec("R7 unsigned narrow", 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 1'b0, 2'b00, 3'b110);
    check("R7 unsigned literal", 64'(pred), 64'h0);
  endtask

  task automatic t_nowrap;
    // R8 32-bit unsigned top of range: only two elements
    run_vec("R8 u32 top", 64'hAAAA_0000_FFFF_FFFE, 64'h5555_0000_FFFF_FFFF, 1'b0, 2'b00, 3'b111);
    check("R8 u32 literal", 64'(pred), 64'h3);
    check("R8 u32 flags", 64'(nzcv), 64'b1010);
    // R8 64-bit signed top of range
    run_vec("R8 s64 top", 64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 2'b10, 3'b011);
    check("R8 s64 literal", 64'(pred), 64'h11);
    // R8 64-bit unsigned top of range
    run_vec("R8 u64 top", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b11, 3'b111);
    check("R8 u64 literal", 64'(pred), 64'h1);
  endtask

  task automatic t_badcode;
    run_vec("R9 code 000", 64'd0, 64'd100, 1'b1, 2'b00, 3'b000);
    check("R9 mask", 64'(pred), 64'd0);
    check("R9 flags", 64'(nzcv), 64'b0110);
    run_vec("R9 code 101", 64'd0, 64'd100, 1'b1, 2'b00, 3'b101);
  endtask

  task automatic t_hold;
    logic [PW-1:0] p0;
    logic [3:0] f0;
    run_vec("R3 setup", 64'd0, 64'd3, 1'b1, 2'b00, 3'b010);
    p0 = pred; f0 = nzcv;
    @(negedge clk);
    op_a = 64'd0; op_b = 64'd100; size = 2'b00; cmp = 3'b010; valid_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 hold pred", 64'(pred), 64'(p0));
    check("R3 hold nzcv", 64'(nzcv), 64'(f0));
    check("R1 idle valid", 64'(valid_out), 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_in = 1'b0; op_a = '0; op_b = '0;
    is64 = 1'b1; size = 2'b00; cmp = 3'b010;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_kinds();
    t_sizes();
    t_prefix();
    t_narrow();
    t_nowrap();
    t_badcode();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule